// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps procedure return addresses in dedicated hardware storage, for a core that has no register-indirect forward jump. It sits beside the decode stage and sees each decoded instruction together with its PC and a valid strobe. A direct jump-and-link whose link bit is set records the address of the next sequential instruction. A dedicated return instruction takes the most recent record and hands it back as the next PC.

The old destination-register field of the jump-and-link no longer names a register. Its lowest bit (instruction bit 7) chooses whether the call links, and its upper four bits widen the jump offset. The register-indirect jump opcode is rejected as illegal. A return with an empty stack, or a linking call with a full stack, raises a fault. In both cases the block gives no redirect and leaves the stack as it was. All outputs are combinational on the current instruction. The stack changes on the next rising clock edge.

Top module: `call_return_stack`

## Requirements
- R1: A valid JAL (opcode 1101111) with instruction bit 7 set and a stack that is not full pushes PC+4, asserts redirect_o and targets PC plus the jump offset.
- R2: A valid JAL with bit 7 clear redirects to PC plus the jump offset and leaves the stack contents and depth unchanged.
- R3: The jump offset is sign-extended from the 25-bit value {instr[31], instr[11:8], instr[19:12], instr[20], instr[30:21], 0}. Target addition wraps modulo 2^XLEN.
- R4: A valid RETURN (instruction exactly 0x0000000B) on a non-empty stack asserts redirect_o with target_o equal to the most recently pushed address, and pops it (last in, first out).
- R5: A linking JAL while 16 entries are held asserts overflow_o, gives no redirect and does not change the stack.
- R6: A RETURN on an empty stack asserts underflow_o, gives no redirect and does not change the stack.
- R7: The opcode 1100111 (JALR), and opcode 0001011 with any other bit non-zero, assert illegal_o, give no redirect and do not change the stack.
- R8: With valid_i low, all outputs are low and the stack is unchanged, whatever instr_i holds.
- R9: Any other valid opcode gives no redirect and no fault, and does not change the stack. At most one of redirect_o, illegal_o, overflow_o and underflow_o is high at a time.
- R10: Reset empties the stack, so the first RETURN after reset underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | instr_i and pc_i hold a decoded instruction |
| instr_i | input | 32 | Instruction word |
| pc_i | input | XLEN | PC of the instruction |
| redirect_o | output | 1 | Take target_o as the next PC |
| target_o | output | XLEN | Redirect address |
| illegal_o | output | 1 | Forbidden encoding seen |
| overflow_o | output | 1 | Linking call with a full stack |
| underflow_o | output | 1 | Return with an empty stack |

## Verification
Random streams mix linking calls, plain jumps, returns, rejected indirect jumps, malformed return encodings, unrelated opcodes and idle cycles. A software LIFO in the bench predicts each output, so these streams separate the stack update from the plain jump path at every depth. Directed runs fill the stack to exactly 16 entries and then attempt one more call, which tests the full boundary. They then drain it in reverse order past empty, which tests both the pop order and underflow. Short sequences confirm that an idle strobe, a rejected indirect jump and a non-linking jump each leave the top entry for the next return.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_CALL,
    OP_JUMP,
    OP_RET,
    OP_BAD
  } op_kind_e;

  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_CUST0 = 7'b0001011;
  localparam int         LINK_BIT  = 7;
  localparam int         OFF_W     = 25;
endpackage

// File: rtl/crs_decode.sv
module crs_decode
  import crs_pkg::*;
(
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  output op_kind_e         kind_o,
  output logic [OFF_W-1:0] offset_o
);
  always_comb begin
    kind_o = OP_NONE;
    if (valid_i) begin
      case (instr_i[6:0])
        OPC_JAL:   kind_o = instr_i[LINK_BIT] ? OP_CALL : OP_JUMP;
        OPC_JALR:  kind_o = OP_BAD;
        OPC_CUST0: kind_o = (instr_i[31:7] == '0) ? OP_RET : OP_BAD;
        default:   kind_o = OP_NONE;
      endcase
    end
  end

  // freed rd bits [11:8] sit just below the sign bit
  assign offset_o = {instr_i[31], instr_i[11:8], instr_i[19:12],
                     instr_i[20], instr_i[30:21], 1'b0};
endmodule

// File: rtl/crs_target.sv
module crs_target
  import crs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0]  jump_tgt_o,
  output logic [XLEN-1:0]  link_addr_o
);
  logic [XLEN-1:0] off_ext;

  generate
    if (XLEN > OFF_W) begin : g_ext
      assign off_ext = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    end else begin : g_trunc
      assign off_ext = offset_i[XLEN-1:0];
    end
  endgenerate

  assign jump_tgt_o  = pc_i + off_ext;
  assign link_addr_o = pc_i + XLEN'(4);
endmodule

// File: rtl/crs_lifo.sv
module crs_lifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_m1;
  logic [WIDTH-1:0] mem_q [DEPTH];

  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign count_m1 = count_q - CNT_W'(1);
  assign top_o    = mem_q[count_m1[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  count_q <= '0;
    else if (push_i && !full_o)   count_q <= count_q + CNT_W'(1);
    else if (pop_i && !empty_o)   count_q <= count_m1;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[i] <= '0;
        else if (push_i && !full_o && count_q[PTR_W-1:0] == PTR_W'(i))
          mem_q[i] <= data_i;
      end
    end
  endgenerate

  assert_no_push_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_pop_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_push_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> count_q == $past(count_q) + CNT_W'(1));
  assert_pop_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> count_q == $past(count_q) - CNT_W'(1));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(count_q));
  assert_one_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/call_return_stack.sv
module call_return_stack
  import crs_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DEPTH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o,
  output logic            illegal_o,
  output logic            overflow_o,
  output logic            underflow_o
);
  op_kind_e         kind;
  logic [OFF_W-1:0] offset;
  logic [XLEN-1:0]  jump_tgt, link_addr, top;
  logic             full, empty, push, pop;

  crs_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .kind_o  (kind),
    .offset_o(offset)
  );

  crs_target #(.XLEN(XLEN)) u_tgt (
    .pc_i       (pc_i),
    .offset_i   (offset),
    .jump_tgt_o (jump_tgt),
    .link_addr_o(link_addr)
  );

  crs_lifo #(.DEPTH(DEPTH), .WIDTH(XLEN)) u_lifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (link_addr),
    .top_o  (top),
    .full_o (full),
    .empty_o(empty)
  );

  assign push        = (kind == OP_CALL) && !full;
  assign pop         = (kind == OP_RET) && !empty;
  assign overflow_o  = (kind == OP_CALL) && full;
  assign underflow_o = (kind == OP_RET) && empty;
  assign illegal_o   = (kind == OP_BAD);
  assign redirect_o  = push || pop || (kind == OP_JUMP);
  assign target_o    = (kind == OP_RET) ? top : jump_tgt;

  assert_fault_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o || underflow_o || illegal_o) |-> !redirect_o);
  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redirect_o, illegal_o, overflow_o, underflow_o}));
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !(redirect_o || illegal_o || overflow_o || underflow_o));
  assert_jalr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[6:0] == OPC_JALR) |-> illegal_o);
endmodule

// File: tb/call_return_stack_test.sv
module call_return_stack_test;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int DEPTH = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic            redirect_o, illegal_o, overflow_o, underflow_o;
  logic [XLEN-1:0] target_o;

  int total = 0;
  int bad = 0;
  logic [31:0] mdl [DEPTH];
  int sp = 0;

  call_return_stack #(.XLEN(XLEN), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .pc_i(pc_i), .redirect_o(redirect_o), .target_o(target_o),
    .illegal_o(illegal_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] jal_off(logic [31:0] w);
    int v;
    v = int'(w[30:21]) * 2 + int'(w[20]) * 2048 + int'(w[19:12]) * 4096
      + int'(w[11:8]) * (1 << 20) - int'(w[31]) * (1 << 24);
    return 32'(v);
  endfunction

  function automatic logic [31:0] mk_jal(logic link);
    logic [31:0] r;
    r = $urandom;
    return {r[31:8], link, 7'b1101111};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one instruction, check outputs mid-cycle, update model at edge
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] pc);
    logic e_red, e_ill, e_ovf, e_unf;
    logic [31:0] e_tgt;
    string req;
    valid_i = v; instr_i = w; pc_i = pc;
    #1;
    e_red = 0; e_ill = 0; e_ovf = 0; e_unf = 0; e_tgt = '0; req = "R9";
    if (!v) req = "R8";
    else if (w[6:0] == 7'b1101111) begin
      e_tgt = pc + jal_off(w);
      if (w[7]) begin
        req = "R1";
        if (sp == DEPTH) begin e_ovf = 1; req = "R5"; end
        else begin e_red = 1; mdl[sp] = pc + 32'd4; sp++; end
      end else begin
        req = "R2"; e_red = 1;
      end
    end else if (w[6:0] == 7'b1100111) begin
      req = "R7"; e_ill = 1;
    end else if (w[6:0] == 7'b0001011) begin
      if (w == 32'h0000000B) begin
        req = "R4";
        if (sp == 0) begin e_unf = 1; req = "R6"; end
        else begin sp--; e_red = 1; e_tgt = mdl[sp]; end
      end else begin
        req = "R7"; e_ill = 1;
      end
    end
    chk(redirect_o == e_red, req, "redirect", 32'(redirect_o), 32'(e_red));
    chk(illegal_o == e_ill, req, "illegal", 32'(illegal_o), 32'(e_ill));
    chk(overflow_o == e_ovf, req, "overflow", 32'(overflow_o), 32'(e_ovf));
    chk(underflow_o == e_unf, req, "underflow", 32'(underflow_o), 32'(e_unf));
    if (e_red) chk(target_o == e_tgt, (req == "R2") ? "R3" : req, "target", target_o, e_tgt);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // reset state with idle input
    chk(!redirect_o && !illegal_o && !overflow_o && !underflow_o, "R10", "reset outputs",
        {28'd0, redirect_o, illegal_o, overflow_o, underflow_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1, 32'h0000000B, 32'h100);           // R10: empty after reset
    // fill to capacity, then one more linking call
    for (int i = 0; i < DEPTH; i++) step(1, mk_jal(1), 32'h1000 + 32'(i) * 64);
    step(1, mk_jal(1), 32'h9000);             // R5
    step(1, 32'h00000067, 32'h9004);          // R7 JALR
    step(1, 32'h0000008B, 32'h9008);          // R7 malformed return
    // drain in reverse, then underflow
    for (int i = 0; i < DEPTH; i++) step(1, 32'h0000000B, 32'h2000);
    step(1, 32'h0000000B, 32'h2000);          // R6
    // idle strobe, JALR and plain jump keep the top entry
    step(1, mk_jal(1), 32'h3000);
    step(0, 32'h0000000B, 32'h3100);          // R8
    step(1, 32'h000000E7, 32'h3104);          // R7
    step(1, mk_jal(0), 32'h3108);             // R2
    step(1, 32'h00000033, 32'h310C);          // R9
    step(1, 32'h0000000B, 32'h3110);          // R4 -> 0x3004
    // extreme offsets (R3)
    step(1, 32'h80000F6F, 32'h00000000);
    step(1, 32'h7FFFFF6F, 32'hFFFFFFF0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r, pc;
      r = $urandom;
      pc = {$urandom} & 32'hFFFFFFFC;
      case ($urandom % 10)
        0, 1, 2: step(1, mk_jal(1), pc);
        3:       step(1, mk_jal(0), pc);
        4, 5:    step(1, 32'h0000000B, pc);
        6:       step(1, {r[31:7], 7'b1100111}, pc);
        7:       step(1, {r[31:7], 7'b0110011}, pc);
        8:       step(0, r, pc);
        default: step(1, {r[31:8], 1'b1, 7'b0001011}, pc);
      endcase
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule